// File: doc/BRIEF.md
# Rotating-Start Ring Element Selector

This block drives the unit-element enable lines of a thermometer-coded current-steering DAC that is used as a test stimulus source. The N = 2^ELEM_BITS elements sit on a logical ring. The block produces p = 2^PASS_BITS complete ramps, called passes, and each ramp runs from zero to all elements on. Every pass begins at a different element. The start elements are spaced q = N/p positions apart, so each output code is reproduced p times, each time with a different set of physical elements. The selection pattern is fixed and does not depend on any data. No scrambler and no random source is used.

Each pass begins with every element off. The element at the pass's start position is then fed a 1 continuously, and the ring shifts that 1 onward, so each clock turns on exactly one more element. When all elements are on, the next clock clears the ring. The following pass then starts from the next start position. When `start` arrives with `auto_adv` high, all passes run in order. When `start` arrives with `auto_adv` low, only the pass chosen by `pass_sel` runs. After the last pass a one-cycle `done` pulse is issued, and the outputs stay at zero until the next start.

Top module: `rotating_ring_sel`

## Requirements
- R1: While reset is asserted and after its release, `elem_en`, `code`, `pass_idx` and `done` are all zero until a start is accepted.
- R2: A start sampled while idle begins a pass. On the cycle after that edge, `elem_en` is all zero and `code` is 0. Each later pass also begins with one all-zero cycle.
- R3: Within a pass, each clock after the zero cycle turns on exactly one additional element. `code` always equals the number of set bits in `elem_en`.
- R4: In pass d (0-based) with code k, the enabled bits are exactly positions (d*q + j) mod N for j = 0..k-1. Bit i of `elem_en` is element i, and the ring wraps from bit N-1 to bit 0.
- R5: Within a pass, an element that is on stays on until the ring is cleared.
- R6: The cycle after `code` reaches N, all elements are off and `code` is 0. In auto mode, if this was not the last pass, `pass_idx` has increased by one.
- R7: With `auto_adv` high at start, passes 0, 1, …, p-1 run in order. Each pass lasts N+1 cycles.
- R8: With `auto_adv` low at start, only pass `pass_sel` runs, and `done` follows it.
- R9: `start`, `auto_adv` and `pass_sel` are ignored while a pass sequence is running.
- R10: `done` is high for exactly the one cycle after the final all-on cycle. During that cycle, and until the next start, `elem_en`, `code` and `pass_idx` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins a sequence when sampled high while idle |
| auto_adv | input | 1 | 1: run all passes; 0: run one pass |
| pass_sel | input | PASS_BITS | Pass to run when auto_adv is 0 |
| elem_en | output | 2^ELEM_BITS | Element enables, bit i = ring position i |
| code | output | ELEM_BITS+1 | Number of elements currently on |
| pass_idx | output | PASS_BITS | Current pass number |
| done | output | 1 | One-cycle pulse at the end of a sequence |

## Verification
Several properties are checked on every cycle: `code` matches the population of `elem_en`, each step adds exactly one new element, no element drops out mid-pass, the first element of a pass is the start position, the ring clears after the full state, and `done` is a quiet single-cycle pulse. The exact wrapped position of every enabled element, the order of passes, single-pass selection and the ignoring of `start` mid-run are shown only by the bench. The bench sweeps every code of every pass on a 16-element, 4-pass configuration and compares each cycle against a computed ring window.

// File: rtl/ring_sel_pkg.sv
`timescale 1ns/1ps
package ring_sel_pkg;
   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_RUN  = 1'b1
   } sel_state_e;
endpackage

// File: rtl/ring_sel_shift.sv
`timescale 1ns/1ps
// Ring of enable flops: each bit copies its predecessor, the start bit is fed a 1.
module ring_sel_shift #(
   parameter int ELEM_BITS = 8
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  clr,
   input  logic                  step,
   input  logic [ELEM_BITS-1:0]  inj_idx,
   output logic [(1<<ELEM_BITS)-1:0] en
);
   localparam int N = 1 << ELEM_BITS;

   logic [N-1:0] nxt;

   for (genvar i = 0; i < N; i++) begin : g_cell
      localparam int PREV = (i == 0) ? N - 1 : i - 1;
      localparam logic [ELEM_BITS-1:0] POS = ELEM_BITS'(i);
      assign nxt[i] = en[PREV] | (inj_idx == POS);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     en <= '0;
      else if (clr)   en <= '0;
      else if (step)  en <= nxt;
   end

   // R5: a step never removes an element
   a_r5_step_keeps: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !clr) |=> ((~en & $past(en)) == '0));
endmodule

// File: rtl/ring_sel_ctrl.sv
`timescale 1ns/1ps
module ring_sel_ctrl
   import ring_sel_pkg::*;
#(
   parameter int ELEM_BITS = 8,
   parameter int PASS_BITS = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start,
   input  logic                 auto_adv,
   input  logic [PASS_BITS-1:0] pass_sel,
   output logic                 step,
   output logic                 clr,
   output logic [ELEM_BITS-1:0] inj_idx,
   output logic [ELEM_BITS:0]   code,
   output logic [PASS_BITS-1:0] pass_idx,
   output logic                 done
);
   localparam int N  = 1 << ELEM_BITS;
   localparam int QB = ELEM_BITS - PASS_BITS;
   localparam logic [ELEM_BITS:0] FULL = (ELEM_BITS+1)'(N);

   sel_state_e st;
   logic       single;
   logic       full;

   assign full = (st == ST_RUN) && (code == FULL);
   assign step = (st == ST_RUN) && !full;
   assign clr  = full;

   // start position = pass * q; q is a power of two, so a shift
   if (QB == 0) begin : g_stride_one
      assign inj_idx = pass_idx;
   end else begin : g_stride_wide
      assign inj_idx = {pass_idx, {QB{1'b0}}};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= ST_IDLE;
         code     <= '0;
         pass_idx <= '0;
         single   <= 1'b0;
         done     <= 1'b0;
      end else begin
         done <= 1'b0;
         case (st)
            ST_IDLE: begin
               if (start) begin
                  st       <= ST_RUN;
                  code     <= '0;
                  pass_idx <= auto_adv ? '0 : pass_sel;
                  single   <= !auto_adv;
               end
            end
            default: begin
               if (full) begin
                  code <= '0;
                  if (single || (&pass_idx)) begin
                     st       <= ST_IDLE;
                     pass_idx <= '0;
                     done     <= 1'b1;
                  end else begin
                     pass_idx <= pass_idx + 1'b1;
                  end
               end else begin
                  code <= code + 1'b1;
               end
            end
         endcase
      end
   end

   // R10: done never repeats on consecutive cycles
   a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   // R9: pass number is stable inside a pass
   a_r9_pass_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_RUN && !full) |=> (pass_idx == $past(pass_idx)));
endmodule

// File: rtl/rotating_ring_sel.sv
`timescale 1ns/1ps
module rotating_ring_sel #(
   parameter int ELEM_BITS = 8,
   parameter int PASS_BITS = 2
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          start,
   input  logic                          auto_adv,
   input  logic [PASS_BITS-1:0]          pass_sel,
   output logic [(1<<ELEM_BITS)-1:0]     elem_en,
   output logic [ELEM_BITS:0]            code,
   output logic [PASS_BITS-1:0]          pass_idx,
   output logic                          done
);
   localparam int N = 1 << ELEM_BITS;
   localparam int QB = ELEM_BITS - PASS_BITS;
   localparam logic [ELEM_BITS:0] FULL = (ELEM_BITS+1)'(N);

   if (ELEM_BITS < 1 || ELEM_BITS > 12) begin : g_bad_elem
      $error("ELEM_BITS must lie in 1..12");
   end
   if (PASS_BITS < 1 || PASS_BITS > ELEM_BITS) begin : g_bad_pass
      $error("PASS_BITS must lie in 1..ELEM_BITS");
   end

   logic                 step;
   logic                 clr;
   logic [ELEM_BITS-1:0] inj_idx;

   ring_sel_ctrl #(.ELEM_BITS(ELEM_BITS), .PASS_BITS(PASS_BITS)) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .auto_adv (auto_adv),
      .pass_sel (pass_sel),
      .step     (step),
      .clr      (clr),
      .inj_idx  (inj_idx),
      .code     (code),
      .pass_idx (pass_idx),
      .done     (done)
   );

   ring_sel_shift #(.ELEM_BITS(ELEM_BITS)) u_ring (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (clr),
      .step    (step),
      .inj_idx (inj_idx),
      .en      (elem_en)
   );

   logic [N-1:0] first_elem;
   assign first_elem = {{(N-1){1'b0}}, 1'b1} << (int'(pass_idx) << QB);

   a_r3_code_is_popcount: assert property (@(posedge clk) disable iff (!rst_n)
      ($countones(elem_en) == int'(code)));
   a_r3_one_new_elem: assert property (@(posedge clk) disable iff (!rst_n)
      (code != '0) |-> ($countones(elem_en & ~$past(elem_en)) == 1));
   a_r5_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
      (code != '0) |-> ((~elem_en & $past(elem_en)) == '0));
   a_r4_first_at_start: assert property (@(posedge clk) disable iff (!rst_n)
      (code == 1) |-> (elem_en == first_elem));
   a_r6_clear_after_full: assert property (@(posedge clk) disable iff (!rst_n)
      (code == FULL) |=> (code == '0 && elem_en == '0));
   a_r6_pass_advance: assert property (@(posedge clk) disable iff (!rst_n)
      (code == FULL) |=> (done || pass_idx == PASS_BITS'($past(pass_idx) + 1'b1)));
   a_r10_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (elem_en == '0 && code == '0 && pass_idx == '0));
endmodule

// File: tb/rotating_ring_sel_tb.sv
`timescale 1ns/1ps
module rotating_ring_sel_tb;
   localparam int EB = 4;
   localparam int PB = 2;
   localparam int N  = 1 << EB;
   localparam int P  = 1 << PB;
   localparam int Q  = N / P;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic          auto_adv = 1'b0;
   logic [PB-1:0] pass_sel = '0;
   logic [N-1:0]  elem_en;
   logic [EB:0]   code;
   logic [PB-1:0] pass_idx;
   logic          done;

   int total = 0;
   int bad   = 0;

   always #4 clk = ~clk;

   rotating_ring_sel #(.ELEM_BITS(EB), .PASS_BITS(PB)) u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .auto_adv(auto_adv),
      .pass_sel(pass_sel), .elem_en(elem_en), .code(code),
      .pass_idx(pass_idx), .done(done)
   );

   task automatic chk(input bit ok, input string req,
                      input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [N-1:0] win(input int d, input int k);
      logic [N-1:0] v = '0;
      for (int i = 0; i < N; i++)
         if (((i - d * Q + N) % N) < k) v[i] = 1'b1;
      return v;
   endfunction

   task automatic idle_zero(input string req);
      chk(elem_en == '0, req, elem_en, 0);
      chk(code == '0, req, code, 0);
      chk(pass_idx == '0, req, pass_idx, 0);
   endtask

   // Called at the negedge after the edge that began pass d.
   task automatic run_pass(input int d, input int poke_k, input string plab);
      logic [N-1:0] prev;
      prev = '0;
      for (int k = 0; k <= N; k++) begin
         chk(elem_en == win(d, k), (k == 0) ? "R2" : "R4", elem_en, win(d, k));
         chk(int'(code) == k, "R3", code, k);
         chk(int'(pass_idx) == d, (k == 0 && d > 0 && plab == "R7") ? "R6" : plab,
             pass_idx, d);
         chk(done == 1'b0, "R10", done, 0);
         chk((prev & ~elem_en) == '0, "R5", elem_en, prev);
         prev = elem_en;
         if (k == poke_k) begin
            start    = 1'b1;
            auto_adv = 1'b0;
            pass_sel = PB'(P - 1);
         end
         @(negedge clk);
         start = 1'b0;
      end
   endtask

   task automatic finish_seq();
      chk(done == 1'b1, "R10", done, 1);
      idle_zero("R10");
      @(negedge clk);
      chk(done == 1'b0, "R10", done, 0);
      repeat (3) @(negedge clk);
      chk(done == 1'b0, "R10", done, 0);
      idle_zero("R10");
   endtask

   initial begin
      #800000;
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      idle_zero("R1");
      chk(done == 1'b0, "R1", done, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      idle_zero("R1");

      // R7: full auto sequence
      start = 1'b1; auto_adv = 1'b1;
      @(negedge clk);
      start = 1'b0;
      for (int d = 0; d < P; d++) run_pass(d, -1, "R7");
      finish_seq();

      // R8: single-pass selection of every pass
      for (int s = 0; s < P; s++) begin
         start = 1'b1; auto_adv = 1'b0; pass_sel = PB'(s);
         @(negedge clk);
         start = 1'b0; pass_sel = '0;
         run_pass(s, -1, "R8");
         finish_seq();
      end

      // R9: start mid-run with other settings is ignored
      start = 1'b1; auto_adv = 1'b1;
      @(negedge clk);
      start = 1'b0;
      for (int d = 0; d < P; d++) run_pass(d, (d == 1) ? 5 : -1, "R9");
      finish_seq();

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule